// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block chooses which of three oscillators clocks the system: the on-chip oscillator, an external crystal, or an external RC network whose supply is taken from a general-purpose pin. Software posts a request naming the wanted source, a crystal drive code and an on-chip frequency setting. The sequencer then carries out the hand-over in hardware, one step per cycle. Any wait it needs is counted in cycles of the on-chip oscillator, which clocks the block.

Every switch starts by parking the system clock on the on-chip oscillator. To reach the crystal, the sequencer first releases the RC supply pin to high impedance. It then turns on the crystal drive and waits a fixed number of cycles. Only after that does it look for the crystal-valid flag, and it selects the external input once the flag is seen. To reach the RC network, it stops the crystal drive, powers the pin in push-pull mode, and selects the external input without any wait. If the crystal never reports valid, the clock stays on the on-chip oscillator, the crystal is stopped, and a sticky error is raised.

The oscillators themselves and the glitch-free clock mux lie outside the block. It drives their enable, drive-code and select controls.

Top module: `clksrc_sequencer`

## Requirements
- R1: After reset, the internal source is selected. This means `clk_sel_ext`=0, `cur_src`=00, `xtal_en`=0, `xtal_drive`=000, `rc_pin_drive`=0 (open-drain), `int_freq`=00, `busy`=0 and `xtal_err`=0.
- R2: A pulse on `req_valid` with `req_src` 00 (internal), 01 (crystal) or 10 (RC) is accepted, and `busy` reads 1 from the next cycle until the sequence ends. Code 11 is ignored: `busy` stays 0 and no output changes.
- R3: Each sequence first clears `clk_sel_ext` and sets `cur_src` to 00 before it touches the pin or the crystal. `cur_src` never moves directly between 01 and 10. While `clk_sel_ext`=1, neither the pin mode nor the crystal controls change.
- R4: On a crystal request, `rc_pin_drive` is 0 before `xtal_en` rises. `xtal_drive` then takes the requested code. `clk_sel_ext` rises with `cur_src`=01 only when `xtal_valid` is high, and no sooner than WAIT_CYC cycles after `xtal_en` rose. This holds even if `xtal_valid` was already high.
- R5: On an RC request, `xtal_en`=0 and `xtal_drive`=000 before `rc_pin_drive` rises. The sequence then ends with `clk_sel_ext`=1 and `cur_src`=10, with no start-up wait.
- R6: On an internal request, the sequence ends with `clk_sel_ext`=0, `cur_src`=00, the crystal stopped (`xtal_en`=0, code 000) and the pin open-drain.
- R7: If `xtal_valid` stays low for TMO_CYC cycles after the wait, the sequence ends on the internal source with the crystal stopped and `xtal_err`=1. The error stays set until the next request is accepted.
- R8: A request that arrives while a sequence runs is held and carried out afterwards. If several arrive, the latest one wins.
- R9: `int_freq` takes the requested code when a request is accepted. The codes are 00=2 MHz, 01=4 MHz, 10=8 MHz and 11=16 MHz.
- R10: `rc_pin_latch` is always 1. The pin therefore drives high in push-pull mode and floats in open-drain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_src | input | 2 | Wanted source: 00 internal, 01 crystal, 10 RC |
| req_drive | input | 3 | Crystal drive code to apply |
| req_freq | input | 2 | On-chip frequency code |
| xtal_valid | input | 1 | Crystal running-and-stable flag |
| clk_sel_ext | output | 1 | Mux select: 1 = external input |
| cur_src | output | 2 | Source currently clocking the system |
| int_freq | output | 2 | On-chip oscillator frequency code |
| xtal_en | output | 1 | Crystal drive enable |
| xtal_drive | output | 3 | Crystal drive code, 000 when stopped |
| rc_pin_drive | output | 1 | RC pin mode: 1 push-pull, 0 open-drain |
| rc_pin_latch | output | 1 | RC pin latch value |
| busy | output | 1 | Sequence running or request pending |
| xtal_err | output | 1 | Sticky crystal start-up timeout |

## Verification
The assertions assume that `xtal_valid` is a synchronous level, meaning it is settled at each clock edge. They also assume that the request fields are stable in any cycle where `req_valid` is high. The bench changes all of these inputs only at falling edges. It raises `xtal_valid` either before the request, to show that the start-up wait is not skipped, or never, to force the timeout. Requests are driven as single-cycle strobes, and some of them land in the middle of a running sequence.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'b00,
        SRC_XTAL = 2'b01,
        SRC_RC   = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PARK,
        S_XT_STOP,
        S_RC_OFF,
        S_XT_START,
        S_XT_WAIT,
        S_XT_POLL,
        S_XT_SEL,
        S_RC_ON,
        S_EXT_SEL
    } state_e;

    typedef struct packed {
        src_e       src;
        logic [2:0] drive;
        logic [1:0] freq;
    } req_t;

    typedef struct packed {
        state_e     st;
        src_e       tgt;
        logic [2:0] code;
        src_e       cur;
        logic       sel_ext;
        logic       xen;
        logic [2:0] drv;
        logic       pp;
        logic [1:0] freq;
        logic       err;
    } seq_t;

endpackage

// File: rtl/clkseq_req_hold.sv
module clkseq_req_hold
    import clkseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  req_t in_req,
    input  logic take,
    output logic pend_valid,
    output req_t pend
);

    typedef struct packed {
        logic vld;
        req_t req;
    } hold_t;

    hold_t h_d, h_q;
    logic  accept;

    always_comb begin
        h_d    = h_q;
        accept = in_valid && (in_req.src != SRC_RSVD);
        if (accept) begin
            h_d.vld = 1'b1;
            h_d.req = in_req;
        end else if (take) begin
            h_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{vld: 1'b0, req: '{src: SRC_INT, drive: 3'b000, freq: 2'b00}};
        end else begin
            h_q <= h_d;
        end
    end

    assign pend_valid = h_q.vld;
    assign pend       = h_q.req;

    // R2 / R8: a legal request is always held on the next cycle
    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_req.src != SRC_RSVD) |=> (pend_valid && pend.src == $past(in_req.src)));

    // R8: a held request is not lost without being taken
    a_r8_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !take) |=> pend_valid);

endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R4 / R7: the wait and timeout windows never wrap the counter
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q != '1));

endmodule

// File: rtl/clksrc_sequencer.sv
module clksrc_sequencer
    import clkseq_pkg::*;
#(
    parameter int WAIT_CYC = 16000,
    parameter int TMO_CYC  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_src,
    input  logic [2:0] req_drive,
    input  logic [1:0] req_freq,
    input  logic       xtal_valid,
    output logic       clk_sel_ext,
    output logic [1:0] cur_src,
    output logic [1:0] int_freq,
    output logic       xtal_en,
    output logic [2:0] xtal_drive,
    output logic       rc_pin_drive,
    output logic       rc_pin_latch,
    output logic       busy,
    output logic       xtal_err
);

    localparam int MAXC  = (WAIT_CYC > TMO_CYC) ? WAIT_CYC : TMO_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_CYC - 1);

    seq_t             q, n;
    logic             take;
    logic             tclr, tinc;
    logic             pend_valid;
    req_t             pend;
    req_t             in_req;
    logic [CNT_W-1:0] cnt;

    assign in_req = '{src: src_e'(req_src), drive: req_drive, freq: req_freq};

    clkseq_req_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_req     (in_req),
        .take       (take),
        .pend_valid (pend_valid),
        .pend       (pend)
    );

    clkseq_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tclr),
        .inc   (tinc),
        .cnt   (cnt)
    );

    always_comb begin
        n    = q;
        take = 1'b0;
        tclr = 1'b0;
        tinc = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (pend_valid) begin
                    take   = 1'b1;
                    n.tgt  = pend.src;
                    n.code = pend.drive;
                    n.freq = pend.freq;
                    n.err  = 1'b0;
                    n.st   = S_PARK;
                end
            end
            S_PARK: begin
                n.sel_ext = 1'b0;
                n.cur     = SRC_INT;
                n.st      = (q.tgt == SRC_XTAL) ? S_RC_OFF : S_XT_STOP;
            end
            S_XT_STOP: begin
                n.xen = 1'b0;
                n.drv = 3'b000;
                n.st  = (q.tgt == SRC_RC) ? S_RC_ON : S_RC_OFF;
            end
            S_RC_OFF: begin
                n.pp = 1'b0;
                n.st = (q.tgt == SRC_XTAL) ? S_XT_START : S_IDLE;
            end
            S_XT_START: begin
                n.xen = 1'b1;
                n.drv = q.code;
                tclr  = 1'b1;
                n.st  = S_XT_WAIT;
            end
            S_XT_WAIT: begin
                if (cnt == WAIT_LAST) begin
                    tclr = 1'b1;
                    n.st = S_XT_POLL;
                end else begin
                    tinc = 1'b1;
                end
            end
            S_XT_POLL: begin
                if (xtal_valid) begin
                    n.st = S_XT_SEL;
                end else if (cnt == TMO_LAST) begin
                    n.err = 1'b1;
                    n.xen = 1'b0;
                    n.drv = 3'b000;
                    tclr  = 1'b1;
                    n.st  = S_IDLE;
                end else begin
                    tinc = 1'b1;
                end
            end
            S_XT_SEL: begin
                n.sel_ext = 1'b1;
                n.cur     = SRC_XTAL;
                n.st      = S_IDLE;
            end
            S_RC_ON: begin
                n.pp = 1'b1;
                n.st = S_EXT_SEL;
            end
            S_EXT_SEL: begin
                n.sel_ext = 1'b1;
                n.cur     = SRC_RC;
                n.st      = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, tgt: SRC_INT, code: 3'b000, cur: SRC_INT,
                   sel_ext: 1'b0, xen: 1'b0, drv: 3'b000, pp: 1'b0,
                   freq: 2'b00, err: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign clk_sel_ext  = q.sel_ext;
    assign cur_src      = q.cur;
    assign int_freq     = q.freq;
    assign xtal_en      = q.xen;
    assign xtal_drive   = q.drv;
    assign rc_pin_drive = q.pp;
    assign rc_pin_latch = 1'b1;
    assign busy         = (q.st != S_IDLE) || pend_valid;
    assign xtal_err     = q.err;

    // R3: no direct move between the two external sources
    a_r3_via_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cur != SRC_INT && $past(q.cur) != SRC_INT) |-> (q.cur == $past(q.cur)));

    // R3: pin and crystal controls only move while parked on internal
    a_r3_quiet_when_ext: assert property (@(posedge clk) disable iff (!rst_n)
        q.sel_ext |-> ($stable(q.xen) && $stable(q.pp) && $stable(q.drv)));

    // R4: crystal never driven while the RC pin is powered
    a_r4_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
        q.xen |-> !q.pp);

    // R4: crystal chosen only after the valid flag was seen
    a_r4_valid_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_XT_SEL) |-> $past(xtal_valid));

    // R5: RC selected only with its pin powered and crystal stopped
    a_r5_rc_powered: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel_ext && q.cur == SRC_RC) |-> (q.pp && !q.xen && q.drv == 3'b000));

    // R7: error is sticky until a new request is taken
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !take) |=> q.err);

endmodule

// File: tb/clksrc_sequencer_test.sv
module clksrc_sequencer_test;

    localparam int WAIT = 20;
    localparam int TMO  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_src = 2'b00;
    logic [2:0] req_drive = 3'b000;
    logic [1:0] req_freq = 2'b00;
    logic       xtal_valid = 1'b0;
    logic       clk_sel_ext, xtal_en, rc_pin_drive, rc_pin_latch, busy, xtal_err;
    logic [1:0] cur_src, int_freq;
    logic [2:0] xtal_drive;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clksrc_sequencer #(.WAIT_CYC(WAIT), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_drive(req_drive), .req_freq(req_freq), .xtal_valid(xtal_valid),
        .clk_sel_ext(clk_sel_ext), .cur_src(cur_src), .int_freq(int_freq),
        .xtal_en(xtal_en), .xtal_drive(xtal_drive), .rc_pin_drive(rc_pin_drive),
        .rc_pin_latch(rc_pin_latch), .busy(busy), .xtal_err(xtal_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ordering monitor (R3, R4, R5)
    logic p_xen = 1'b0, p_pp = 1'b0, p_sel = 1'b0, p_drv_nz = 1'b0;
    logic [1:0] p_cur = 2'b00;
    int xcnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (xtal_en && !p_xen) begin
                check("R4 pin open before crystal start", int'(rc_pin_drive), 0);
                xcnt = 0;
            end else begin
                xcnt++;
            end
            if (rc_pin_drive && !p_pp)
                check("R5 crystal off before pin drive", int'(xtal_en || xtal_drive != 0), 0);
            if (clk_sel_ext && !p_sel && cur_src == 2'b01) begin
                check("R4 valid at crystal select", int'(xtal_valid), 1);
                check("R4 start wait honoured", int'(xcnt >= WAIT), 1);
            end
            if ((p_cur == 2'b01 && cur_src == 2'b10) || (p_cur == 2'b10 && cur_src == 2'b01))
                check("R3 direct external move", 1, 0);
            if (clk_sel_ext && p_sel &&
                (xtal_en != p_xen || rc_pin_drive != p_pp || (xtal_drive != 0) != p_drv_nz))
                check("R3 controls moved while external", 1, 0);
        end
        p_xen = xtal_en; p_pp = rc_pin_drive; p_sel = clk_sel_ext;
        p_cur = cur_src; p_drv_nz = (xtal_drive != 0);
    end

    task automatic send(input logic [1:0] src, input logic [2:0] drv, input logic [1:0] fr);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_drive = drv; req_freq = fr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R2 sequence finishes", int'(busy), 0);
    endtask

    task automatic t_reset();
        check("R1 sel_ext", int'(clk_sel_ext), 0);
        check("R1 cur_src", int'(cur_src), 0);
        check("R1 xtal_en", int'(xtal_en), 0);
        check("R1 drive", int'(xtal_drive), 0);
        check("R1 pin", int'(rc_pin_drive), 0);
        check("R1 freq", int'(int_freq), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 err", int'(xtal_err), 0);
        check("R10 latch", int'(rc_pin_latch), 1);
    endtask

    task automatic t_to_rc();
        send(2'b10, 3'b011, 2'b00);
        check("R2 busy after accept", int'(busy), 1);
        wait_idle();
        check("R5 sel_ext", int'(clk_sel_ext), 1);
        check("R5 cur_src", int'(cur_src), 2);
        check("R5 pin push-pull", int'(rc_pin_drive), 1);
        check("R5 crystal off", int'(xtal_en), 0);
        check("R10 latch", int'(rc_pin_latch), 1);
    endtask

    task automatic t_reserved();
        send(2'b11, 3'b111, 2'b11);
        check("R2 reserved not busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        check("R2 reserved cur_src", int'(cur_src), 2);
        check("R2 reserved freq", int'(int_freq), 0);
        check("R2 reserved pin", int'(rc_pin_drive), 1);
    endtask

    task automatic t_rc_to_xtal();
        xtal_valid = 1'b1;
        send(2'b01, 3'b101, 2'b01);
        wait_idle();
        check("R4 sel_ext", int'(clk_sel_ext), 1);
        check("R4 cur_src", int'(cur_src), 1);
        check("R4 drive code", int'(xtal_drive), 5);
        check("R4 pin released", int'(rc_pin_drive), 0);
        check("R9 freq 4MHz code", int'(int_freq), 1);
    endtask

    task automatic t_to_int();
        send(2'b00, 3'b000, 2'b11);
        wait_idle();
        check("R6 sel_ext", int'(clk_sel_ext), 0);
        check("R6 cur_src", int'(cur_src), 0);
        check("R6 crystal off", int'(xtal_en), 0);
        check("R6 drive off", int'(xtal_drive), 0);
        check("R6 pin open", int'(rc_pin_drive), 0);
        check("R9 freq 16MHz code", int'(int_freq), 3);
    endtask

    task automatic t_timeout();
        xtal_valid = 1'b0;
        send(2'b01, 3'b111, 2'b10);
        wait_idle();
        check("R7 err set", int'(xtal_err), 1);
        check("R7 on internal", int'(clk_sel_ext), 0);
        check("R7 cur_src", int'(cur_src), 0);
        check("R7 crystal stopped", int'(xtal_en), 0);
        check("R7 drive stopped", int'(xtal_drive), 0);
        repeat (5) @(negedge clk);
        check("R7 err sticky", int'(xtal_err), 1);
        send(2'b10, 3'b000, 2'b10);
        wait_idle();
        check("R7 err cleared by request", int'(xtal_err), 0);
        check("R7 rc after clear", int'(cur_src), 2);
    endtask

    task automatic t_queued();
        xtal_valid = 1'b1;
        send(2'b01, 3'b010, 2'b00);
        repeat (2) @(negedge clk);
        send(2'b10, 3'b000, 2'b00);
        check("R8 busy while queued", int'(busy), 1);
        wait_idle();
        check("R8 queued rc done", int'(cur_src), 2);
        check("R8 queued rc pin", int'(rc_pin_drive), 1);
        send(2'b01, 3'b010, 2'b00);
        repeat (3) @(negedge clk);
        send(2'b10, 3'b000, 2'b00);
        send(2'b00, 3'b000, 2'b10);
        wait_idle();
        check("R8 latest wins cur_src", int'(cur_src), 0);
        check("R8 latest wins sel", int'(clk_sel_ext), 0);
        check("R9 freq 8MHz code", int'(int_freq), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_to_rc();
        t_reserved();
        t_rc_to_xtal();
        t_to_int();
        t_to_rc();
        t_timeout();
        t_queued();
        repeat (5) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule